// File: doc/BRIEF.md
# Dual-Port UART Register Mimic

This block is a register file with two ports. On one side, a PC host bus sees the usual 16550-style UART register set through a 3-bit address and read and write strobes. On the other side, a local microprocessor reads and writes the same storage. It uses these registers as a mailbox and emulates the serial engine in firmware. The block itself does no shifting, baud generation, FIFO handling or line signalling.

Only a few behaviours are wired in hardware. Setting the top bit of the line control register steers host addresses 0 and 1 to the divisor latch bytes. A loop setting in the modem control register mirrors four control outputs into the modem status view. The host interrupt pin has an output enable that Out2 controls, but only when the processor selects one particular gating mode.

Every other control bit is plain storage that the processor reads back. A host read of modem status clears the delta flags that the processor set.

Top module: `uart_reg_mimic`

## Requirements
- R1: After reset every register reads 0 on both ports. The divisor latch select and the loop setting are therefore off, and the interrupt pin is driven (enable 1) with value 0.
- R2: While line control bit 7 is 1, host reads and writes at address 0 reach the divisor low byte (processor address 10). At address 1 they reach the divisor high byte (processor address 11).
- R3: While line control bit 7 is 1, host writes at addresses 0 and 1 leave the transmit holding byte (processor address 1) and the interrupt enable byte (processor address 2) unchanged. While the bit is 0, address 0 writes the transmit byte and reads the receive byte (processor address 0), and address 1 reads and writes the interrupt enable byte.
- R4: The line control register is host address 3 and processor address 5. All 8 bits are stored and read back, and bits 6..0 have no other effect.
- R5: The modem control register is host address 4 and processor address 6. Bits 7..5 always read 0.
- R6: When modem control bit 4 (loop) is 1, a host read at address 6 returns bit7=Out2 (control bit 3), bit6=Out1 (control bit 2), bit5=DTR (control bit 0), bit4=RTS (control bit 1), and bits 3..0 = 0.
- R7: When loop is 0, host address 6 returns the status byte written by the processor at address 8. A host read strobe at address 6 clears bits 3..0 of that byte on the next clock and keeps bits 7..4. If the processor writes address 8 in the same cycle, the written byte is stored with bits 3..0 cleared.
- R8: Processor address 12 holds bit0 = interrupt request and bits 2..1 = gating mode. When the mode is binary 10 and Out2 is 0, the interrupt output enable is 0. Otherwise the enable is 1 and the pin carries the request bit.
- R9: A host write appears at the processor port on the next clock. When both ports write the same register in one cycle, the host value is kept.
- R10: Host address 2 reads the identification byte that the processor writes at address 3. Host writes to address 2 store the FIFO control byte, which the processor reads at address 4. Host address 5 reads the line status byte that the processor writes at address 7. Host writes to addresses 5 and 6 change nothing. Host address 7 is a scratch byte, which the processor sees at address 9.
- R11: Processor addresses 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clears the status deltas at address 6) |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| mpu_addr | input | MPU_AW | Processor register address |
| mpu_wdata | input | 8 | Processor write data |
| mpu_wr | input | 1 | Processor write strobe |
| mpu_rdata | output | 8 | Processor read data, combinational from mpu_addr |
| host_irq | output | 1 | Host interrupt value |
| host_irq_oe | output | 1 | Host interrupt output enable; 0 means high impedance |

## Verification
The assertions check four things on every cycle:
- modem control always reads back with its reserved bits at zero;
- the host read strobe clears the status deltas;
- the host wins a write collision;
- the divisor-select bit shields the transmit byte, and the loop view carries Out2 in place of the stored status.

Only the bench's scenarios can show the complete address redirect in both directions, every bit of the loopback mapping, the mailbox path through each register pair, the gating of the interrupt enable in each mode, and the reset values.

// File: rtl/uart_reg_mimic.sv
module uart_reg_mimic #(
  parameter int MPU_AW = 4,
  parameter logic [1:0] GATE_MODE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic [MPU_AW-1:0] mpu_addr,
  input  logic [7:0]        mpu_wdata,
  input  logic              mpu_wr,
  output logic [7:0]        mpu_rdata,
  output logic              host_irq,
  output logic              host_irq_oe
);
  localparam int NREG = 1 << MPU_AW;

  logic [7:0] rbr, thr, ier, iir, fcr, lcr, lsr, msr_src, scr, dll, dlm;
  logic [4:0] mcr;
  logic [2:0] ctl;
  logic [NREG-1:0] m_sel;

  wire dlab = lcr[7];
  wire loop = mcr[4];

  assign m_sel = mpu_wr ? (NREG'(1) << mpu_addr) : '0;

  wire h0  = host_wr && host_addr == 3'd0;
  wire h1  = host_wr && host_addr == 3'd1;
  wire h_thr = h0 && !dlab;
  wire h_dll = h0 && dlab;
  wire h_ier = h1 && !dlab;
  wire h_dlm = h1 && dlab;
  wire h_fcr = host_wr && host_addr == 3'd2;
  wire h_lcr = host_wr && host_addr == 3'd3;
  wire h_mcr = host_wr && host_addr == 3'd4;
  wire h_scr = host_wr && host_addr == 3'd7;
  wire msr_clr = host_rd && host_addr == 3'd6;

  wire [7:0] msr_view = loop ? {mcr[3], mcr[2], mcr[0], mcr[1], 4'b0000} : msr_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr <= '0; thr <= '0; ier <= '0; iir <= '0; fcr <= '0; lcr <= '0;
      lsr <= '0; msr_src <= '0; scr <= '0; dll <= '0; dlm <= '0;
      mcr <= '0; ctl <= '0;
    end else begin
      if (m_sel[0]) rbr <= mpu_wdata;

      if (h_thr) thr <= host_wdata;
      else if (m_sel[1]) thr <= mpu_wdata;

      if (h_ier) ier <= host_wdata;
      else if (m_sel[2]) ier <= mpu_wdata;

      if (m_sel[3]) iir <= mpu_wdata;

      if (h_fcr) fcr <= host_wdata;
      else if (m_sel[4]) fcr <= mpu_wdata;

      if (h_lcr) lcr <= host_wdata;
      else if (m_sel[5]) lcr <= mpu_wdata;

      if (h_mcr) mcr <= host_wdata[4:0];
      else if (m_sel[6]) mcr <= mpu_wdata[4:0];

      if (m_sel[7]) lsr <= mpu_wdata;

      if (msr_clr)
        msr_src <= {m_sel[8] ? mpu_wdata[7:4] : msr_src[7:4], 4'b0000};
      else if (m_sel[8])
        msr_src <= mpu_wdata;

      if (h_scr) scr <= host_wdata;
      else if (m_sel[9]) scr <= mpu_wdata;

      if (h_dll) dll <= host_wdata;
      else if (m_sel[10]) dll <= mpu_wdata;

      if (h_dlm) dlm <= host_wdata;
      else if (m_sel[11]) dlm <= mpu_wdata;

      if (m_sel[12]) ctl <= mpu_wdata[2:0];
    end
  end

  always_comb begin
    case (host_addr)
      3'd0:    host_rdata = dlab ? dll : rbr;
      3'd1:    host_rdata = dlab ? dlm : ier;
      3'd2:    host_rdata = iir;
      3'd3:    host_rdata = lcr;
      3'd4:    host_rdata = {3'b000, mcr};
      3'd5:    host_rdata = lsr;
      3'd6:    host_rdata = msr_view;
      default: host_rdata = scr;
    endcase
  end

  always_comb begin
    case (mpu_addr)
      MPU_AW'(0):  mpu_rdata = rbr;
      MPU_AW'(1):  mpu_rdata = thr;
      MPU_AW'(2):  mpu_rdata = ier;
      MPU_AW'(3):  mpu_rdata = iir;
      MPU_AW'(4):  mpu_rdata = fcr;
      MPU_AW'(5):  mpu_rdata = lcr;
      MPU_AW'(6):  mpu_rdata = {3'b000, mcr};
      MPU_AW'(7):  mpu_rdata = lsr;
      MPU_AW'(8):  mpu_rdata = msr_src;
      MPU_AW'(9):  mpu_rdata = scr;
      MPU_AW'(10): mpu_rdata = dll;
      MPU_AW'(11): mpu_rdata = dlm;
      MPU_AW'(12): mpu_rdata = {5'b00000, ctl};
      default:     mpu_rdata = 8'h00;
    endcase
  end

  wire gated = ctl[2:1] == GATE_MODE;
  assign host_irq_oe = !(gated && !mcr[3]);
  assign host_irq    = ctl[0];
endmodule

// File: rtl/uart_reg_mimic_chk.sv
module uart_reg_mimic_chk #(
  parameter int MPU_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        host_addr,
  input logic [7:0]        host_wdata,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic [MPU_AW-1:0] mpu_addr,
  input logic              mpu_wr,
  input logic [7:0]        mpu_rdata,
  input logic [7:0]        lcr,
  input logic [4:0]        mcr,
  input logic [7:0]        thr,
  input logic [7:0]        msr_src
);
  p_mcr_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 3'd4) |-> (host_rdata[7:5] == 3'b000));

  p_mpu_mcr_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mpu_addr == MPU_AW'(6)) |-> (mpu_rdata[7:5] == 3'b000));

  p_delta_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd6) |=> (msr_src[3:0] == 4'h0));

  p_host_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd3 && mpu_wr && mpu_addr == MPU_AW'(5))
      |=> (lcr == $past(host_wdata)));

  p_dlab_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd0 && lcr[7] && !(mpu_wr && mpu_addr == MPU_AW'(1)))
      |=> $stable(thr));

  p_loop_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr[4] && host_addr == 3'd6) |-> (host_rdata[3:0] == 4'h0 && host_rdata[7] == mcr[3]));
endmodule

bind uart_reg_mimic uart_reg_mimic_chk #(.MPU_AW(MPU_AW)) u_chk (.*);

// File: tb/tb_uart_reg_mimic.sv
module tb_uart_reg_mimic;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic [3:0] mpu_addr = '0;
  logic [7:0] mpu_wdata = '0;
  logic       mpu_wr = 1'b0;
  logic [7:0] mpu_rdata;
  logic       host_irq, host_irq_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_reg_mimic dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata),
    .mpu_addr(mpu_addr), .mpu_wdata(mpu_wdata), .mpu_wr(mpu_wr), .mpu_rdata(mpu_rdata),
    .host_irq(host_irq), .host_irq_oe(host_irq_oe)
  );

  // kind: 0 host write, 1 host check, 2 mpu write, 3 mpu check; {kind, addr, data, req}
  localparam int NV = 44;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 4'd3,  8'h80, 4'd2},  // R2 divisor select on
    {2'd0, 4'd0,  8'h34, 4'd2},
    {2'd0, 4'd1,  8'h12, 4'd2},
    {2'd1, 4'd0,  8'h34, 4'd2},
    {2'd1, 4'd1,  8'h12, 4'd2},
    {2'd3, 4'd10, 8'h34, 4'd2},
    {2'd3, 4'd11, 8'h12, 4'd2},
    {2'd3, 4'd1,  8'h00, 4'd3},  // R3 THR shielded
    {2'd3, 4'd2,  8'h00, 4'd3},  // R3 IER shielded
    {2'd0, 4'd3,  8'h1B, 4'd4},  // R4
    {2'd3, 4'd5,  8'h1B, 4'd4},
    {2'd1, 4'd3,  8'h1B, 4'd4},
    {2'd0, 4'd0,  8'hA5, 4'd3},
    {2'd3, 4'd1,  8'hA5, 4'd3},
    {2'd2, 4'd0,  8'h5A, 4'd3},
    {2'd1, 4'd0,  8'h5A, 4'd3},
    {2'd0, 4'd1,  8'h0F, 4'd3},
    {2'd1, 4'd1,  8'h0F, 4'd3},
    {2'd3, 4'd2,  8'h0F, 4'd3},
    {2'd0, 4'd4,  8'hFF, 4'd5},  // R5
    {2'd1, 4'd4,  8'h1F, 4'd5},
    {2'd3, 4'd6,  8'h1F, 4'd5},
    {2'd1, 4'd6,  8'hF0, 4'd6},  // R6 all four mirrored
    {2'd0, 4'd4,  8'h15, 4'd6},
    {2'd1, 4'd6,  8'h60, 4'd6},
    {2'd0, 4'd4,  8'h1A, 4'd6},
    {2'd1, 4'd6,  8'h90, 4'd6},
    {2'd0, 4'd4,  8'h00, 4'd7},  // R7
    {2'd2, 4'd8,  8'hC3, 4'd7},
    {2'd1, 4'd6,  8'hC3, 4'd7},
    {2'd2, 4'd3,  8'hC2, 4'd10}, // R10
    {2'd1, 4'd2,  8'hC2, 4'd10},
    {2'd0, 4'd2,  8'h87, 4'd10},
    {2'd3, 4'd4,  8'h87, 4'd10},
    {2'd3, 4'd3,  8'hC2, 4'd10},
    {2'd2, 4'd7,  8'h60, 4'd10},
    {2'd1, 4'd5,  8'h60, 4'd10},
    {2'd0, 4'd5,  8'hFF, 4'd10},
    {2'd3, 4'd7,  8'h60, 4'd10},
    {2'd0, 4'd7,  8'h3C, 4'd10},
    {2'd3, 4'd9,  8'h3C, 4'd10},
    {2'd0, 4'd6,  8'hFF, 4'd10},
    {2'd3, 4'd8,  8'hC3, 4'd10},
    {2'd3, 4'd13, 8'h00, 4'd11}  // R11
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic mw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); mpu_addr = a; mpu_wdata = d; mpu_wr = 1'b1;
    @(negedge clk); mpu_wr = 1'b0;
  endtask

  task automatic hc(input logic [2:0] a, input logic [7:0] e, input int req);
    @(negedge clk); host_addr = a; #1;
    check(req, host_rdata, e, "host read");
  endtask

  task automatic mc(input logic [3:0] a, input logic [7:0] e, input int req);
    @(negedge clk); mpu_addr = a; #1;
    check(req, mpu_rdata, e, "mpu read");
  endtask

  task automatic irq_chk(input logic oe, input logic v, input int req);
    @(negedge clk); #1;
    check(req, {7'b0, host_irq_oe}, {7'b0, oe}, "irq enable");
    if (oe) check(req, {7'b0, host_irq}, {7'b0, v}, "irq value");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    hc(3'd3, 8'h00, 1); hc(3'd4, 8'h00, 1); hc(3'd6, 8'h00, 1);
    mc(4'd5, 8'h00, 1); mc(4'd12, 8'h00, 1); mc(4'd10, 8'h00, 1);
    irq_chk(1'b1, 1'b0, 1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: hw(VEC[i][14:12], VEC[i][11:4]);
        2'd1: hc(VEC[i][14:12], VEC[i][11:4], int'(VEC[i][3:0]));
        2'd2: mw(VEC[i][15:12], VEC[i][11:4]);
        default: mc(VEC[i][15:12], VEC[i][11:4], int'(VEC[i][3:0]));
      endcase
    end
    mc(4'd15, 8'h00, 11);

    // R7 host read strobe clears deltas
    @(negedge clk); host_addr = 3'd6; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    hc(3'd6, 8'hC0, 7); mc(4'd8, 8'hC0, 7);
    // R7 collision with processor write
    @(negedge clk); host_addr = 3'd6; host_rd = 1'b1; mpu_addr = 4'd8; mpu_wdata = 8'hFF; mpu_wr = 1'b1;
    @(negedge clk); host_rd = 1'b0; mpu_wr = 1'b0;
    mc(4'd8, 8'hF0, 7);

    // R9 simultaneous write, host wins
    @(negedge clk); host_addr = 3'd3; host_wdata = 8'h2A; host_wr = 1'b1;
    mpu_addr = 4'd5; mpu_wdata = 8'h55; mpu_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0; mpu_wr = 1'b0;
    mc(4'd5, 8'h2A, 9); hc(3'd3, 8'h2A, 9);
    // R9 next-clock visibility
    @(negedge clk); host_addr = 3'd7; host_wdata = 8'h99; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0; mpu_addr = 4'd9; #1;
    check(9, mpu_rdata, 8'h99, "next-clock mirror");

    // R8 interrupt gating
    mw(4'd12, 8'h05);
    irq_chk(1'b0, 1'b1, 8);
    hw(3'd4, 8'h08);
    irq_chk(1'b1, 1'b1, 8);
    hw(3'd4, 8'h00);
    mw(4'd12, 8'h07);
    irq_chk(1'b1, 1'b1, 8);
    mw(4'd12, 8'h00);
    irq_chk(1'b1, 1'b0, 8);

    // R1 reset mid-run
    hw(3'd3, 8'h80);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    hc(3'd3, 8'h00, 1); mc(4'd9, 8'h00, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule